// File: doc/BRIEF.md
# Register Last-Writer Trace Monitor

This block is a synthesizable debug monitor that sits beside a CPU core and watches one architectural register. It answers one question: which write last changed the register before a chosen instruction address retired? A single live record tracks the most recent change. On every retire at a programmable trigger address, that record is copied into a small snapshot buffer together with the register's value and the current pass (epoch) index. This avoids a fill-from-reset trace, which overflows long before the event of interest.

The core supplies the register value, a retire strobe with its PC, its FSM state code, a pass index and a free-running cycle count. Each change is credited to the FSM state registered one cycle earlier, because that is the state whose action produced the new value. Each change is tagged as a restore write, a normal write or some other source, using configured state codes. Saturating counters summarise the run. Snapshot entries and counters come back through a registered read port.

Configuration (trigger PC, restore-state code, execute-state code) is accepted only while the monitor is disarmed. Arming clears the buffer, the counters and the record-valid bit.

Top module: `reg_writer_tracer`

## Requirements
- R1: A value change is seen in a cycle whose `watch_val` differs from the previous cycle's (only while armed, and never in the first cycle after reset). The live record then takes the cycle count, FSM state and PC sampled in the cycle before, plus the new value, and its valid bit is set.
- R2: While armed, a cycle with `retire_vld`=1 and `retire_pc` equal to the trigger PC stores a snapshot entry. The entry holds `watch_val` of that cycle, the live record as it stood at the start of that cycle, and `pass_idx`.
- R3: The buffer keeps at most 16 entries in arrival order. Later trigger retires are counted but not stored.
- R4: The recorded state is the FSM state of the cycle before the change appears, not the state of the cycle in which it appears.
- R5: The source tag is 2'd2 (restore) if the recorded state equals the restore code, else 2'd1 (normal) if it equals the execute code, else 2'd3 (other). A snapshot taken while the record is invalid stores tag 2'd0 (none) and zero record fields.
- R6: Counter 0 counts value changes. Counter 1 counts value changes seen while `pass_idx` is not 0.
- R7: The `armed` output shows the arm state. Counter 2 counts trigger retires, and counter 5 gives the number of stored entries.
- R8: `cfg_we` with `cfg_sel` 0/1/2 loads the trigger PC, restore code or execute code only while disarmed. While armed these writes have no effect.
- R9: `cfg_sel`=3 with `cfg_wdata[0]`=1 arms a disarmed monitor and clears the counters, buffer and record-valid bit. With `cfg_wdata[0]`=0 it disarms and keeps all contents.
- R10: Counter 3 (counter 4) counts trigger retires with `pass_idx`≠0 and `watch_val`==1 whose valid record is tagged restore (normal).
- R11: All counters saturate at their all-ones value.
- R12: `rd_en` with `rd_addr[4]`=0 returns entry `rd_addr[3:0]` on the entry outputs one cycle later, all zero if that index is not stored. With `rd_addr[4]`=1, counter `rd_addr[2:0]` appears on `rd_cnt` (selectors 6 and 7 read 0). `rd_valid` follows `rd_en` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| watch_val | input | DW | Current value of the watched register |
| retire_vld | input | 1 | Instruction retire strobe |
| retire_pc | input | PCW | PC of the retiring instruction |
| fsm_state | input | SW | Core FSM state code |
| pass_idx | input | PW | Pass or epoch index |
| cycle_cnt | input | CW | Free-running cycle count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 trigger PC, 1 restore code, 2 execute code, 3 arm control |
| cfg_wdata | input | PCW | Configuration write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | RAW | Entry index or counter selector |
| armed | output | 1 | Monitor armed |
| rd_valid | output | 1 | Read data valid |
| rd_val | output | DW | Entry: watched value at the retire |
| rd_cyc | output | CW | Entry: writer cycle count |
| rd_state | output | SW | Entry: writer FSM state |
| rd_pc | output | PCW | Entry: writer PC |
| rd_wval | output | DW | Entry: value written |
| rd_src | output | 2 | Entry: source tag |
| rd_pass | output | PW | Entry: pass index at the retire |
| rd_cnt | output | CNTW | Selected counter |

## Verification
A wrong live record shows up as a wrong state, PC or tag in the first snapshot read after the faulty change. The most telling case is a change credited to the execute state that follows a restore cycle. An overflow or a wrong arm clear shows at once in the stored-entry count and in zero fields for unstored indexes. Counter faults show within one read of the run that caused them: a wrap past all-ones after a few hundred toggles, or a change counted while disarmed. Configuration leaking through while armed shows as trigger retires that are missed or counted twice.

// File: rtl/reg_writer_tracer.sv
module reg_writer_tracer #(
  parameter int DW = 32,
  parameter int PCW = 32,
  parameter int SW = 4,
  parameter int PW = 8,
  parameter int CW = 32,
  parameter int CNTW = 16,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int RAW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   watch_val,
  input  logic            retire_vld,
  input  logic [PCW-1:0]  retire_pc,
  input  logic [SW-1:0]   fsm_state,
  input  logic [PW-1:0]   pass_idx,
  input  logic [CW-1:0]   cycle_cnt,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PCW-1:0]  cfg_wdata,
  input  logic            rd_en,
  input  logic [RAW-1:0]  rd_addr,
  output logic            armed,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_val,
  output logic [CW-1:0]   rd_cyc,
  output logic [SW-1:0]   rd_state,
  output logic [PCW-1:0]  rd_pc,
  output logic [DW-1:0]   rd_wval,
  output logic [1:0]      rd_src,
  output logic [PW-1:0]   rd_pass,
  output logic [CNTW-1:0] rd_cnt
);
  localparam logic [1:0] SRC_NONE = 2'd0, SRC_NORM = 2'd1, SRC_RST = 2'd2, SRC_OTHER = 2'd3;

  logic [PCW-1:0] trig_pc;
  logic [SW-1:0]  rst_code, exe_code;

  logic [DW-1:0]  val_q;
  logic [SW-1:0]  st_q;
  logic [PCW-1:0] pc_q;
  logic [CW-1:0]  cyc_q;
  logic           seen;

  logic           l_valid;
  logic [CW-1:0]  l_cyc;
  logic [SW-1:0]  l_st;
  logic [PCW-1:0] l_pc;
  logic [DW-1:0]  l_wv;
  logic [1:0]     l_src;

  logic [CNTW-1:0] c_chg, c_late, c_trig, c_one_rst, c_one_nrm;
  logic [IW:0]     n_ent;

  logic [DW-1:0]  e_val  [DEPTH];
  logic [CW-1:0]  e_cyc  [DEPTH];
  logic [SW-1:0]  e_st   [DEPTH];
  logic [PCW-1:0] e_pc   [DEPTH];
  logic [DW-1:0]  e_wv   [DEPTH];
  logic [1:0]     e_src  [DEPTH];
  logic [PW-1:0]  e_pass [DEPTH];

  function automatic logic [CNTW-1:0] bump(input logic [CNTW-1:0] c, input logic en);
    return (en && (c != {CNTW{1'b1}})) ? c + 1'b1 : c;
  endfunction

  wire arm_ctl  = cfg_we && (cfg_sel == 2'd3);
  wire arm_go   = !armed && arm_ctl && cfg_wdata[0];
  wire disarm   = armed && arm_ctl && !cfg_wdata[0];
  wire chg      = armed && seen && (watch_val != val_q);
  wire hit      = armed && retire_vld && (retire_pc == trig_pc);
  wire room     = n_ent < (IW+1)'(DEPTH);
  wire is_one   = watch_val == DW'(1);
  wire late     = pass_idx != '0;
  wire [IW-1:0] widx = n_ent[IW-1:0];
  wire [1:0] src_now = (st_q == rst_code) ? SRC_RST :
                       (st_q == exe_code) ? SRC_NORM : SRC_OTHER;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      trig_pc <= '0;
      rst_code <= '0;
      exe_code <= '0;
      val_q <= '0;
      st_q <= '0;
      pc_q <= '0;
      cyc_q <= '0;
      seen <= 1'b0;
      l_valid <= 1'b0;
      l_cyc <= '0;
      l_st <= '0;
      l_pc <= '0;
      l_wv <= '0;
      l_src <= SRC_NONE;
      c_chg <= '0;
      c_late <= '0;
      c_trig <= '0;
      c_one_rst <= '0;
      c_one_nrm <= '0;
      n_ent <= '0;
    end else begin
      val_q <= watch_val;
      st_q  <= fsm_state;
      pc_q  <= retire_pc;
      cyc_q <= cycle_cnt;
      seen  <= 1'b1;

      if (cfg_we && !armed) begin
        case (cfg_sel)
          2'd0: trig_pc  <= cfg_wdata;
          2'd1: rst_code <= cfg_wdata[SW-1:0];
          2'd2: exe_code <= cfg_wdata[SW-1:0];
          default: ;
        endcase
      end

      if (arm_go) begin
        armed <= 1'b1;
        l_valid <= 1'b0;
        c_chg <= '0;
        c_late <= '0;
        c_trig <= '0;
        c_one_rst <= '0;
        c_one_nrm <= '0;
        n_ent <= '0;
      end else if (disarm) begin
        armed <= 1'b0;
      end

      if (chg) begin
        l_valid <= 1'b1;
        l_cyc <= cyc_q;
        l_st  <= st_q;
        l_pc  <= pc_q;
        l_wv  <= watch_val;
        l_src <= src_now;
        c_chg  <= bump(c_chg, 1'b1);
        c_late <= bump(c_late, late);
      end

      if (hit) begin
        c_trig <= bump(c_trig, 1'b1);
        if (room) n_ent <= n_ent + 1'b1;
        c_one_rst <= bump(c_one_rst, late && is_one && l_valid && (l_src == SRC_RST));
        c_one_nrm <= bump(c_one_nrm, late && is_one && l_valid && (l_src == SRC_NORM));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit && room) begin
      e_val[widx]  <= watch_val;
      e_cyc[widx]  <= l_valid ? l_cyc : '0;
      e_st[widx]   <= l_valid ? l_st  : '0;
      e_pc[widx]   <= l_valid ? l_pc  : '0;
      e_wv[widx]   <= l_valid ? l_wv  : '0;
      e_src[widx]  <= l_valid ? l_src : SRC_NONE;
      e_pass[widx] <= pass_idx;
    end
  end

  logic [CNTW-1:0] cnt_mux;
  always_comb begin
    case (rd_addr[2:0])
      3'd0: cnt_mux = c_chg;
      3'd1: cnt_mux = c_late;
      3'd2: cnt_mux = c_trig;
      3'd3: cnt_mux = c_one_rst;
      3'd4: cnt_mux = c_one_nrm;
      3'd5: cnt_mux = CNTW'(n_ent);
      default: cnt_mux = '0;
    endcase
  end

  wire [IW-1:0] ridx = rd_addr[IW-1:0];
  wire rd_hit = !rd_addr[IW] && ({1'b0, ridx} < n_ent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_val <= '0;
      rd_cyc <= '0;
      rd_state <= '0;
      rd_pc <= '0;
      rd_wval <= '0;
      rd_src <= SRC_NONE;
      rd_pass <= '0;
      rd_cnt <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_val   <= rd_hit ? e_val[ridx]  : '0;
        rd_cyc   <= rd_hit ? e_cyc[ridx]  : '0;
        rd_state <= rd_hit ? e_st[ridx]   : '0;
        rd_pc    <= rd_hit ? e_pc[ridx]   : '0;
        rd_wval  <= rd_hit ? e_wv[ridx]   : '0;
        rd_src   <= rd_hit ? e_src[ridx]  : SRC_NONE;
        rd_pass  <= rd_hit ? e_pass[ridx] : '0;
        rd_cnt   <= rd_addr[IW] ? cnt_mux : '0;
      end
    end
  end
endmodule

// File: rtl/reg_writer_tracer_props.sv
module reg_writer_tracer_props #(
  parameter int PCW = 32,
  parameter int CNTW = 16,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            armed,
  input logic            rd_en,
  input logic            rd_valid,
  input logic            cfg_we,
  input logic [1:0]      cfg_sel,
  input logic [PCW-1:0]  cfg_wdata,
  input logic [PCW-1:0]  trig_pc,
  input logic            l_valid,
  input logic [IW:0]     n_ent,
  input logic [CNTW-1:0] c_chg,
  input logic [CNTW-1:0] c_trig
);
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    n_ent <= (IW+1)'(DEPTH));

  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (c_chg >= $past(c_chg)) && (c_trig >= $past(c_trig)));

  assert_trigger_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfg_we && cfg_sel == 2'd0) |=> $stable(trig_pc));

  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && cfg_we && cfg_sel == 2'd3 && cfg_wdata[0]) |=>
      (armed && !l_valid && n_ent == '0 && c_chg == '0 && c_trig == '0));

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_read_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind reg_writer_tracer reg_writer_tracer_props #(.PCW(PCW), .CNTW(CNTW), .DEPTH(DEPTH)) u_props (
  .clk(clk), .rst_n(rst_n), .armed(armed), .rd_en(rd_en), .rd_valid(rd_valid),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .trig_pc(trig_pc),
  .l_valid(l_valid), .n_ent(n_ent), .c_chg(c_chg), .c_trig(c_trig)
);

// File: tb/reg_writer_tracer_test.sv
module reg_writer_tracer_test;
  localparam int DW = 32, PCW = 32, SW = 4, PW = 8, CW = 32, CNTW = 8, DEPTH = 16, RAW = 5;
  localparam int MAXC = 255;
  localparam logic [3:0] EXEC = 4'd2, RSTW = 4'd5, OTHR = 4'd7;
  localparam logic [31:0] TRIG = 32'h100;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] watch_val = '0;
  logic retire_vld = 0;
  logic [PCW-1:0] retire_pc = '0;
  logic [SW-1:0] fsm_state = '0;
  logic [PW-1:0] pass_idx = '0;
  logic [CW-1:0] cycle_cnt = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [PCW-1:0] cfg_wdata = '0;
  logic rd_en = 0;
  logic [RAW-1:0] rd_addr = '0;
  logic armed, rd_valid;
  logic [DW-1:0] rd_val, rd_wval;
  logic [CW-1:0] rd_cyc;
  logic [SW-1:0] rd_state;
  logic [PCW-1:0] rd_pc;
  logic [1:0] rd_src;
  logic [PW-1:0] rd_pass;
  logic [CNTW-1:0] rd_cnt;

  reg_writer_tracer #(.DW(DW), .PCW(PCW), .SW(SW), .PW(PW), .CW(CW), .CNTW(CNTW), .DEPTH(DEPTH)) uut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic m_armed = 0, m_seen = 0, m_lv = 0;
  logic [31:0] m_pv = 0, m_ppc = 0, m_pcyc = 0, m_trig = 0;
  logic [3:0] m_pst = 0, m_rc = 0, m_ec = 0;
  logic [31:0] m_lcyc = 0, m_lpc = 0, m_lwv = 0;
  logic [3:0] m_lst = 0;
  logic [1:0] m_lsrc = 0;
  int m_cnt [6];
  logic [31:0] x_val [16], x_cyc [16], x_pc [16], x_wv [16];
  logic [3:0] x_st [16];
  logic [1:0] x_src [16];
  logic [7:0] x_pass [16];

  function automatic int sat(int c, bit en);
    return (en && c < MAXC) ? c + 1 : c;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit chg, hit;
    cycle_cnt = cycle_cnt + 1;
    chg = m_armed && m_seen && (watch_val != m_pv);
    hit = m_armed && retire_vld && (retire_pc == m_trig);
    if (hit) begin
      m_cnt[2] = sat(m_cnt[2], 1);
      if (m_cnt[5] < 16) begin
        x_val[m_cnt[5]] = watch_val;
        x_cyc[m_cnt[5]] = m_lv ? m_lcyc : 0;
        x_st[m_cnt[5]]  = m_lv ? m_lst : 0;
        x_pc[m_cnt[5]]  = m_lv ? m_lpc : 0;
        x_wv[m_cnt[5]]  = m_lv ? m_lwv : 0;
        x_src[m_cnt[5]] = m_lv ? m_lsrc : 2'd0;
        x_pass[m_cnt[5]] = pass_idx;
        m_cnt[5]++;
      end
      m_cnt[3] = sat(m_cnt[3], pass_idx != 0 && watch_val == 1 && m_lv && m_lsrc == 2'd2);
      m_cnt[4] = sat(m_cnt[4], pass_idx != 0 && watch_val == 1 && m_lv && m_lsrc == 2'd1);
    end
    if (chg) begin
      m_lv = 1; m_lcyc = m_pcyc; m_lst = m_pst; m_lpc = m_ppc; m_lwv = watch_val;
      m_lsrc = (m_pst == m_rc) ? 2'd2 : (m_pst == m_ec) ? 2'd1 : 2'd3;
      m_cnt[0] = sat(m_cnt[0], 1);
      m_cnt[1] = sat(m_cnt[1], pass_idx != 0);
    end
    if (cfg_we) begin
      if (!m_armed) begin
        if (cfg_sel == 0) m_trig = cfg_wdata;
        if (cfg_sel == 1) m_rc = cfg_wdata[3:0];
        if (cfg_sel == 2) m_ec = cfg_wdata[3:0];
        if (cfg_sel == 3 && cfg_wdata[0]) begin
          m_armed = 1; m_lv = 0;
          for (int k = 0; k < 6; k++) m_cnt[k] = 0;
        end
      end else if (cfg_sel == 3 && !cfg_wdata[0]) m_armed = 0;
    end
    m_pv = watch_val; m_pst = fsm_state; m_ppc = retire_pc; m_pcyc = cycle_cnt; m_seen = 1;
    @(negedge clk);
  endtask

  task automatic drv(logic [31:0] v, logic [3:0] st, logic [31:0] pc, bit rv, logic [7:0] ps);
    watch_val = v; fsm_state = st; retire_pc = pc; retire_vld = rv; pass_idx = ps;
    tick();
    retire_vld = 0;
  endtask

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; retire_vld = 0;
    tick();
    cfg_we = 0;
  endtask

  task automatic rdx(logic [4:0] a);
    rd_en = 1; rd_addr = a; retire_vld = 0;
    tick();
    rd_en = 0;
  endtask

  task automatic chk_counters(string tag);
    for (int k = 0; k < 8; k++) begin
      rdx(5'(16 + k));
      chk("R12", {tag, " rd_valid"}, 64'(rd_valid), 64'd1);
      chk(k == 0 ? "R6" : k == 1 ? "R6" : k == 2 ? "R7" : k < 5 ? "R10" : "R7",
          $sformatf("%s counter %0d", tag, k), 64'(rd_cnt), 64'(k < 6 ? m_cnt[k] : 0));
    end
  endtask

  task automatic chk_entry(int i);
    bit ok = i < m_cnt[5];
    rdx(5'(i));
    chk("R12", $sformatf("entry %0d rd_valid", i), 64'(rd_valid), 64'd1);
    chk("R2", $sformatf("entry %0d value", i), 64'(rd_val), ok ? 64'(x_val[i]) : 64'd0);
    chk("R1", $sformatf("entry %0d cycle", i), 64'(rd_cyc), ok ? 64'(x_cyc[i]) : 64'd0);
    chk("R4", $sformatf("entry %0d state", i), 64'(rd_state), ok ? 64'(x_st[i]) : 64'd0);
    chk("R1", $sformatf("entry %0d pc", i), 64'(rd_pc), ok ? 64'(x_pc[i]) : 64'd0);
    chk("R1", $sformatf("entry %0d written value", i), 64'(rd_wval), ok ? 64'(x_wv[i]) : 64'd0);
    chk("R5", $sformatf("entry %0d source", i), 64'(rd_src), ok ? 64'(x_src[i]) : 64'd0);
    chk("R2", $sformatf("entry %0d pass", i), 64'(rd_pass), ok ? 64'(x_pass[i]) : 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) m_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R7", "armed after reset", 64'(armed), 64'd0);
    chk("R12", "rd_valid after reset", 64'(rd_valid), 64'd0);
    chk_counters("reset");

    cfg(0, TRIG); cfg(1, 32'(RSTW)); cfg(2, 32'(EXEC));
    drv(32'h55, EXEC, 32'h10, 0, 0);
    cfg(3, 1);
    chk("R9", "armed after arm", 64'(armed), 64'd1);
    drv(32'h55, EXEC, TRIG, 1, 0);
    chk_entry(0);
    chk("R5", "no-writer tag is none", 64'(x_src[0]), 64'd0);

    for (int p = 0; p < 20; p++) begin
      drv(32'(p * 16 + 5), EXEC, 32'h40, 1, 8'(p));
      drv(32'(p * 16 + 6), EXEC, 32'h44, 0, 8'(p));
      drv(0, EXEC, 32'h48, 0, 8'(p));
      drv(0, (p % 5 < 3) ? RSTW : (p % 5 == 3) ? EXEC : OTHR, 32'(32'h80 + p), 0, 8'(p));
      drv(1, EXEC, 32'h84, 0, 8'(p));
      drv(1, EXEC, TRIG, 1, 8'(p));
    end
    chk("R4", "restore write credited to prior state", 64'(x_st[1]), 64'(RSTW));
    chk("R3", "stored entries capped", 64'(m_cnt[5]), 64'd16);
    chk("R7", "trigger retires counted past cap", 64'(m_cnt[2]), 64'd21);

    cfg(0, 32'h200);
    drv(1, EXEC, 32'h200, 1, 3);
    drv(1, EXEC, TRIG, 1, 3);
    chk_counters("after locked config");

    for (int i = 0; i < 300; i++) drv(32'(2 + (i & 1)), EXEC, 32'h40, 0, 1);
    chk_counters("saturation");
    chk("R11", "model change count saturated", 64'(m_cnt[0]), 64'(MAXC));
    for (int i = 0; i < 16; i++) chk_entry(i);

    cfg(3, 0);
    chk("R9", "armed after disarm", 64'(armed), 64'd0);
    drv(32'h9, EXEC, TRIG, 1, 4);
    drv(32'hA, EXEC, TRIG, 1, 4);
    chk_counters("disarmed");
    chk_entry(3);

    cfg(3, 1);
    chk_counters("rearm");
    chk_entry(0);
    drv(32'hB, RSTW, 32'h70, 0, 2);
    drv(32'h1, OTHR, 32'h74, 0, 2);
    drv(32'h1, EXEC, TRIG, 1, 2);
    chk_entry(0);
    chk_entry(1);
    chk_counters("final");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule